// File: doc/BRIEF.md
# Embedded Core Test Wrapper

This block sits around an embedded logic core and decides what drives each core terminal. In functional operation, the surrounding logic reaches the core directly. In core test, the core inputs come from a bank of wrapper input cells and the chip-side outputs come from a bank of wrapper output cells. Both banks are loaded and unloaded through a narrow serial test bus. In bypass, test data crosses the wrapper through one register stage, so the interconnect around the core can be exercised without the core's participation.

The test bus is `TB_W` bits wide. The core boundary is `CI_W` inputs and `CO_W` outputs, and both must be multiples of `TB_W`. The input and output cells form one serial chain, with the input cells first. Three strobes act on the chain. A shift advances the chain by one bus slice. A capture loads the live core outputs. An update copies the chain contents onto hold registers that face the core and the chip. The mode select is registered, so a new mode takes effect from the next clock edge.

Top module: `core_test_wrapper`

## Requirements
- R1: After reset the wrapper is in functional mode. All chain and hold registers are zero, so `tam_out` reads 0. On the first entry to core test, `core_in` and `chip_out` read 0.
- R2: In functional mode (select 2'b00), `core_in` equals `func_core_in`, `chip_out` equals `core_out` and `tam_out` is 0. The shift, capture and update strobes leave every wrapper register unchanged.
- R3: Select code 2'b11 behaves exactly as functional mode.
- R4: The mode select is sampled at the clock edge. A change on `mode_sel` does not alter the outputs before the next rising edge.
- R5: In core test (select 2'b01), each shift moves `tam_in` into the top slice of the input cells and moves every slice one position toward bit 0. After `CI_W/TB_W` shifts, the slice shifted first sits at bits [TB_W-1:0].
- R6: In core test, `core_in` shows the input hold register. It changes only on a cycle with `update_en`, so shifting never disturbs it.
- R7: A capture in core test loads `core_out` into the output cells. `tam_out` shows output-cell bits [TB_W-1:0], and each later shift presents the next higher slice.
- R8: In core test and in bypass, `chip_out` shows the output hold register loaded by update. It does not follow the live `core_out`.
- R9: In bypass (select 2'b10), `tam_out` equals the `tam_in` of the previous cycle. The strobes leave the cells untouched, and `core_in`/`chip_out` keep their hold values.
- R10: Capture has priority over shift in the same cycle, and the input cells then do not move. An update in the same cycle as a shift copies the contents from before the shift.
- R11: On a shift, the bottom slice of the input cells enters the top slice of the output cells. The chain thus runs from `tam_in`, through the input cells and then the output cells, to `tam_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Mode select: 00 functional, 01 core test, 10 bypass, 11 as functional |
| shift_en | input | 1 | Shift the cell chain by one slice |
| capture_en | input | 1 | Load core outputs into output cells |
| update_en | input | 1 | Copy cell chain into hold registers |
| tam_in | input | TB_W | Serial test data in |
| tam_out | output | TB_W | Serial test data out |
| func_core_in | input | CI_W | Functional drive toward the core inputs |
| core_in | output | CI_W | Muxed core inputs |
| core_out | input | CO_W | Core outputs |
| chip_out | output | CO_W | Muxed outputs toward surrounding logic |

## Verification
Two cycle collisions get directed stimulus. The first raises shift and capture together on a chain with known contents. It is judged by whether `tam_out` shows the captured core slice and whether a later update reveals that the input cells did not move. The second raises update together with shift. It is judged by `core_in` holding the slice pattern from before the shift. A follow-up update alone must then expose the shifted pattern, with the new slice at the top.

// File: rtl/ctw_pkg.sv
package ctw_pkg;

  typedef enum logic [1:0] {
    WM_FUNC = 2'b00,
    WM_CORE = 2'b01,
    WM_BYP  = 2'b10
  } wmode_e;

  typedef struct packed {
    logic shift;
    logic capture;
    logic update;
  } strobe_t;

  // Reserved select code folds onto functional operation.
  function automatic wmode_e decode_mode(input logic [1:0] sel);
    case (sel)
      2'b01:   return WM_CORE;
      2'b10:   return WM_BYP;
      default: return WM_FUNC;
    endcase
  endfunction

endpackage

// File: rtl/ctw_mode_ctrl.sv
module ctw_mode_ctrl
  import ctw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  output wmode_e     mode_q,
  output logic       test_act,
  output logic       byp_act
);

  wmode_e mode_d;

  always_comb begin
    mode_d = decode_mode(mode_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= WM_FUNC;
    else        mode_q <= mode_d;
  end

  assign test_act = (mode_q == WM_CORE);
  assign byp_act  = (mode_q == WM_BYP);

endmodule

// File: rtl/ctw_boundary_chain.sv
module ctw_boundary_chain
  import ctw_pkg::*;
#(
  parameter int CI_W = 8,
  parameter int CO_W = 8,
  parameter int TB_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  strobe_t         stb,
  input  logic [TB_W-1:0] tam_in,
  input  logic [CO_W-1:0] core_out,
  output logic [CI_W-1:0] in_hold_q,
  output logic [CO_W-1:0] out_hold_q,
  output logic [TB_W-1:0] tail
);

  localparam int IN_SLC  = CI_W / TB_W;
  localparam int OUT_SLC = CO_W / TB_W;

  logic [CI_W-1:0] in_sh_q, in_sh_d, in_shifted;
  logic [CO_W-1:0] out_sh_q, out_sh_d, out_shifted;
  logic            ld_cap, ld_shf, ld_upd;

  // Slice-wise shift path: input cells feed output cells, bottom first.
  for (genvar g = 0; g < IN_SLC; g++) begin : g_in_slc
    if (g == IN_SLC - 1) begin : g_top
      assign in_shifted[g*TB_W +: TB_W] = tam_in;
    end else begin : g_mid
      assign in_shifted[g*TB_W +: TB_W] = in_sh_q[(g+1)*TB_W +: TB_W];
    end
  end

  for (genvar g = 0; g < OUT_SLC; g++) begin : g_out_slc
    if (g == OUT_SLC - 1) begin : g_top
      assign out_shifted[g*TB_W +: TB_W] = in_sh_q[TB_W-1:0];
    end else begin : g_mid
      assign out_shifted[g*TB_W +: TB_W] = out_sh_q[(g+1)*TB_W +: TB_W];
    end
  end

  // Clock enables; capture wins over shift.
  assign ld_cap = en & stb.capture;
  assign ld_shf = en & stb.shift & ~stb.capture;
  assign ld_upd = en & stb.update;

  always_comb begin
    in_sh_d  = in_shifted;
    out_sh_d = ld_cap ? core_out : out_shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_sh_q <= '0;
    end else if (ld_shf) begin
      in_sh_q <= in_sh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sh_q <= '0;
    end else if (ld_cap | ld_shf) begin
      out_sh_q <= out_sh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_hold_q  <= '0;
      out_hold_q <= '0;
    end else if (ld_upd) begin
      in_hold_q  <= in_sh_q;
      out_hold_q <= out_sh_q;
    end
  end

  assign tail = out_sh_q[TB_W-1:0];

endmodule

// File: rtl/ctw_bypass_reg.sv
module ctw_bypass_reg #(
  parameter int TB_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [TB_W-1:0] tam_in,
  output logic [TB_W-1:0] byp_q
);

  for (genvar b = 0; b < TB_W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  byp_q[b] <= 1'b0;
      else if (en) byp_q[b] <= tam_in[b];
    end
  end

endmodule

// File: rtl/core_test_wrapper.sv
module core_test_wrapper
  import ctw_pkg::*;
#(
  parameter int CI_W = 8,
  parameter int CO_W = 8,
  parameter int TB_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode_sel,
  input  logic            shift_en,
  input  logic            capture_en,
  input  logic            update_en,
  input  logic [TB_W-1:0] tam_in,
  output logic [TB_W-1:0] tam_out,
  input  logic [CI_W-1:0] func_core_in,
  output logic [CI_W-1:0] core_in,
  input  logic [CO_W-1:0] core_out,
  output logic [CO_W-1:0] chip_out
);

  wmode_e          mode_q;
  logic            test_act, byp_act;
  strobe_t         stb;
  logic [CI_W-1:0] in_hold;
  logic [CO_W-1:0] out_hold;
  logic [TB_W-1:0] chain_tail, byp_q;

  assign stb = '{shift: shift_en, capture: capture_en, update: update_en};

  ctw_mode_ctrl u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .mode_q   (mode_q),
    .test_act (test_act),
    .byp_act  (byp_act)
  );

  ctw_boundary_chain #(.CI_W(CI_W), .CO_W(CO_W), .TB_W(TB_W)) u_chain (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (test_act),
    .stb        (stb),
    .tam_in     (tam_in),
    .core_out   (core_out),
    .in_hold_q  (in_hold),
    .out_hold_q (out_hold),
    .tail       (chain_tail)
  );

  ctw_bypass_reg #(.TB_W(TB_W)) u_byp (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (byp_act),
    .tam_in (tam_in),
    .byp_q  (byp_q)
  );

  always_comb begin
    case (mode_q)
      WM_CORE: begin
        core_in  = in_hold;
        chip_out = out_hold;
        tam_out  = chain_tail;
      end
      WM_BYP: begin
        core_in  = in_hold;
        chip_out = out_hold;
        tam_out  = byp_q;
      end
      default: begin
        core_in  = func_core_in;
        chip_out = core_out;
        tam_out  = '0;
      end
    endcase
  end

endmodule

// File: rtl/ctw_chk.sv
module ctw_chk #(
  parameter int CI_W = 8,
  parameter int CO_W = 8,
  parameter int TB_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      mode_sel,
  input logic            update_en,
  input logic [TB_W-1:0] tam_in,
  input logic [TB_W-1:0] tam_out,
  input logic [CI_W-1:0] func_core_in,
  input logic [CI_W-1:0] core_in,
  input logic [CO_W-1:0] core_out,
  input logic [CO_W-1:0] chip_out
);

  logic [1:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd0) |-> (tam_out == '0 && core_in == func_core_in));

  // R2
  func_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0 && $past(mode_sel) == 2'b00) |->
      (core_in == func_core_in && chip_out == core_out && tam_out == '0));

  // R3
  reserved_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0 && $past(mode_sel) == 2'b11) |->
      (core_in == func_core_in && chip_out == core_out && tam_out == '0));

  // R6
  core_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && $past(mode_sel) == 2'b01 && $past(mode_sel, 2) == 2'b01
      && !$past(update_en)) |-> $stable(core_in));

  // R8
  chip_out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && $past(mode_sel) == 2'b01 && $past(mode_sel, 2) == 2'b01
      && !$past(update_en)) |-> $stable(chip_out));

  // R9
  bypass_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && $past(mode_sel) == 2'b10 && $past(mode_sel, 2) == 2'b10)
      |-> (tam_out == $past(tam_in)));

endmodule

bind core_test_wrapper ctw_chk #(.CI_W(CI_W), .CO_W(CO_W), .TB_W(TB_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_sel     (mode_sel),
  .update_en    (update_en),
  .tam_in       (tam_in),
  .tam_out      (tam_out),
  .func_core_in (func_core_in),
  .core_in      (core_in),
  .core_out     (core_out),
  .chip_out     (chip_out)
);

// File: tb/tb_core_test_wrapper.sv
module tb_core_test_wrapper;

  localparam int CI_W = 8;
  localparam int CO_W = 8;
  localparam int TB_W = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      mode_sel;
  logic            shift_en, capture_en, update_en;
  logic [TB_W-1:0] tam_in, tam_out;
  logic [CI_W-1:0] func_core_in, core_in;
  logic [CO_W-1:0] core_out, chip_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  core_test_wrapper #(.CI_W(CI_W), .CO_W(CO_W), .TB_W(TB_W)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_sel     (mode_sel),
    .shift_en     (shift_en),
    .capture_en   (capture_en),
    .update_en    (update_en),
    .tam_in       (tam_in),
    .tam_out      (tam_out),
    .func_core_in (func_core_in),
    .core_in      (core_in),
    .core_out     (core_out),
    .chip_out     (chip_out)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; mode_sel = 2'b00;
    shift_en = 0; capture_en = 0; update_en = 0;
    tam_in = '0; func_core_in = 8'h5A; core_out = 8'h3C;
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    chk("R1 core_in", core_in, 8'h5A);
    chk("R1 chip_out", chip_out, 8'h3C);
    chk("R1 tam_out", tam_out, 0);
  endtask

  task automatic t_normal();
    func_core_in = 8'hA5; core_out = 8'hC3;
    #1;
    chk("R2 core_in", core_in, 8'hA5);
    chk("R2 chip_out", chip_out, 8'hC3);
    tam_in = 2'b11; shift_en = 1; capture_en = 1; update_en = 1;
    tick(); tick();
    chk("R2 tam_out", tam_out, 0);
    shift_en = 0; capture_en = 0; update_en = 0; tam_in = '0;
    mode_sel = 2'b01;
    #1;
    chk("R4 no change before edge", core_in, 8'hA5);
    tick();
    chk("R1 R2 core_in zero in test", core_in, 0);
    chk("R1 R2 chip_out zero in test", chip_out, 0);
    chk("R1 R2 chain empty", tam_out, 0);
  endtask

  task automatic t_shift_update();
    logic [7:0] d = 8'hB4;
    for (int i = 0; i < 4; i++) begin
      tam_in = d[2*i +: 2]; shift_en = 1;
      tick();
      chk("R6 core_in held while shifting", core_in, 0);
    end
    shift_en = 0; update_en = 1;
    tick();
    update_en = 0;
    chk("R5 core_in after update", core_in, 8'hB4);
  endtask

  task automatic t_capture_unload();
    logic [7:0] c = 8'h9C;
    logic [7:0] d = 8'hB4;
    core_out = c; capture_en = 1;
    tick();
    capture_en = 0; update_en = 1;
    tick();
    update_en = 0;
    chk("R8 chip_out from hold", chip_out, 8'h9C);
    core_out = 8'h11;
    #1;
    chk("R8 chip_out ignores live core_out", chip_out, 8'h9C);
    for (int k = 0; k < 4; k++) begin
      chk("R7 captured slice", tam_out, c[2*k +: 2]);
      tam_in = '0; shift_en = 1;
      tick();
      shift_en = 0;
    end
    for (int k = 0; k < 4; k++) begin
      chk("R11 input cells reach tam_out", tam_out, d[2*k +: 2]);
      shift_en = 1;
      tick();
      shift_en = 0;
    end
  endtask

  task automatic t_collide();
    logic [7:0] x = 8'h6D;
    for (int i = 0; i < 4; i++) begin
      tam_in = x[2*i +: 2]; shift_en = 1;
      tick();
    end
    core_out = 8'h81; capture_en = 1; shift_en = 1; tam_in = 2'b11;
    tick();
    capture_en = 0;
    chk("R10 capture wins over shift", tam_out, 2'b01);
    update_en = 1; shift_en = 1; tam_in = 2'b11;
    tick();
    shift_en = 0;
    chk("R10 update takes pre-shift cells", core_in, 8'h6D);
    tick();
    update_en = 0;
    chk("R10 shifted cells after later update", core_in, 8'hDB);
    chk("R11 output cells took input slice", chip_out, 8'h60);
  endtask

  task automatic t_bypass();
    logic [1:0] vals [5] = '{2'b01, 2'b10, 2'b11, 2'b00, 2'b10};
    mode_sel = 2'b10;
    tick();
    chk("R9 core_in held in bypass", core_in, 8'hDB);
    chk("R9 chip_out held in bypass", chip_out, 8'h60);
    shift_en = 1; update_en = 1; capture_en = 1; core_out = 8'hFF;
    for (int i = 0; i < 5; i++) begin
      tam_in = vals[i];
      tick();
      chk("R9 one-cycle bypass", tam_out, vals[i]);
    end
    tam_in = 2'b01;
    #1;
    chk("R9 bypass is registered", tam_out, 2'b10);
    chk("R9 strobes inert in bypass", core_in, 8'hDB);
    shift_en = 0; update_en = 0; capture_en = 0;
  endtask

  task automatic t_reserved();
    mode_sel = 2'b11; func_core_in = 8'h33; core_out = 8'h44;
    tick();
    chk("R3 core_in", core_in, 8'h33);
    chk("R3 chip_out", chip_out, 8'h44);
    chk("R3 tam_out", tam_out, 0);
    mode_sel = 2'b01;
    tick();
    chk("R3 hold kept", core_in, 8'hDB);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_shift_update();
    t_capture_unload();
    t_collide();
    t_bypass();
    t_reserved();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule